// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is one channel of a memory-mapped DMA controller. It copies a run of equal-width elements between a fixed device address and a memory address that steps forward by the element width. A neighbouring global block supplies the start pulse, the operating mode and the copy direction. Channel arbitration and the global control registers stay outside this block.

There are two operating modes. In single mode the channel works from the four descriptor registers exactly as software wrote them, then goes idle. In chain mode the next-pointer register gives the address of a descriptor in memory. The channel reads that descriptor, four 32-bit words, into its registers and performs the copy. While the descriptor's flags say more follow, it fetches the next descriptor from the pointer carried in the descriptor just loaded.

Descriptor words are validated before any data moves. A bad width code, or an element count above the limit for its width, stops the channel with an error event.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the state code is 0, no bus request is made, both event outputs are low and all four descriptor registers read 0.
- R2: The register port addresses the descriptors by word index: 0 device address, 1 memory address, 2 size, 3 next. Reads are combinational. Writes take effect only while the state is idle and are ignored while the channel is busy.
- R3: A start with mode 2 (single) copies `count` elements. For each element the channel reads the source and then writes the read word to the destination. Direction 1 reads memory and writes the device; direction 0 reads the device and writes memory. The device address is fixed. The memory address register grows by the element width after each element.
- R4: Size bits 13:12 give the width: 3 means 1 byte, 2 means 2 bytes, 0 means 4 bytes. Bits 11:0 give the count. Width code 1, or a count above 0x3FF (1- or 2-byte width) or above 0x7FF (4-byte width), makes the channel issue no data access. It pulses `err_evt` and `done_evt` together for one cycle and returns to idle.
- R5: When a descriptor ends, `done_evt` pulses for one cycle only if bit 0 of its next word is 1.
- R6: A start with mode 1 (chain) reads four words at the next register's value with bits 1:0 cleared, at offsets +0, +4, +8 and +C, into registers 0..3, then copies. After the copy, if bit 1 of the loaded next word is 1, the channel fetches the descriptor at that word with bits 1:0 cleared; otherwise it returns to idle. Single mode returns to idle whatever bit 1 holds.
- R7: `state_o` is 0 when idle, 2 while a bus request is not granted, 1 during a granted descriptor read, and 3 during a granted data access.
- R8: If mode is 0, the channel is idle with no bus request on the next cycle and raises no event for the abandoned descriptor.
- R9: A descriptor with count 0 makes no data access and ends at once, following its flags.
- R10: A request holds its address and direction until granted. Each grant cycle completes one transfer, with read data taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| start | input | 1 | Start pulse from the global block |
| mode | input | 2 | 0 off, 1 chain, 2 single |
| dir | input | 1 | 1 memory to device, 0 device to memory |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_gnt | input | 1 | Grant; the transfer completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with the grant |
| state_o | output | 2 | Channel state code |
| done_evt | output | 1 | Completion event pulse |
| err_evt | output | 1 | Error event pulse |

## Verification
Single mode is swept over all three widths, both directions, counts 0, 1 and 5, and grant stalls of 0, 1 and 3 cycles. The sweep separates the address stepping per width, the source/destination swap per direction, the empty-descriptor path and the wait-state reporting. Each width is run at its exact count limit and one above it, along with the illegal width code, so that the limit logic is shown to depend on the width. Chain runs cover a follow with interrupt, an empty descriptor in mid-chain and a last descriptor. A chain whose second descriptor is malformed shows that the error happens after the fetch and before any data access. An abort and a register write during a busy copy show that the channel drops its work at once and keeps its working registers.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int CNT_W      = 12,
  parameter int MAX_NARROW = 'h3FF,
  parameter int MAX_WIDE   = 'h7FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic        dir,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_gnt,
  input  logic [31:0] bus_rdata,
  output logic [1:0]  state_o,
  output logic        done_evt,
  output logic        err_evt
);
  localparam logic [1:0] PH_IDLE = 2'd0, PH_FETCH = 2'd1, PH_RD = 2'd2, PH_WR = 2'd3;

  logic [1:0]       ph, widx;
  logic             chain_r;
  logic [31:0]      dev_r, mem_r, size_r, next_r, base_r, hold_r;
  logic [CNT_W-1:0] cnt_r;

  wire [1:0]       wcode  = size_r[CNT_W+1:CNT_W];
  wire [CNT_W-1:0] count  = size_r[CNT_W-1:0];
  wire [31:0]      wbytes = (wcode == 2'd3) ? 32'd1 : (wcode == 2'd2) ? 32'd2 : 32'd4;
  wire [CNT_W-1:0] limit  = (wcode == 2'd0) ? CNT_W'(MAX_WIDE) : CNT_W'(MAX_NARROW);
  wire             bad    = (wcode == 2'd1) || (count > limit);
  wire [31:0]      nxt    = (ph == PH_FETCH) ? bus_rdata : next_r;

  wire launch = (ph == PH_IDLE && start && mode == 2'd2) ||
                (ph == PH_FETCH && bus_gnt && widx == 2'd3);
  wire finish = (launch && !bad && count == '0) ||
                (ph == PH_WR && bus_gnt && cnt_r == CNT_W'(1));
  wire follow = ph != PH_IDLE && chain_r && nxt[1];

  assign bus_req   = ph != PH_IDLE;
  assign bus_we    = ph == PH_WR;
  assign bus_wdata = hold_r;
  assign state_o   = (ph == PH_IDLE) ? 2'd0 : !bus_gnt ? 2'd2 : (ph == PH_FETCH) ? 2'd1 : 2'd3;

  always_comb begin
    case (ph)
      PH_FETCH: bus_addr = base_r + {28'd0, widx, 2'b00};
      PH_RD:    bus_addr = dir ? mem_r : dev_r;
      PH_WR:    bus_addr = dir ? dev_r : mem_r;
      default:  bus_addr = 32'd0;
    endcase
  end

  always_comb begin
    case (reg_idx)
      2'd0:    reg_rdata = dev_r;
      2'd1:    reg_rdata = mem_r;
      2'd2:    reg_rdata = size_r;
      default: reg_rdata = next_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; widx <= '0; chain_r <= 1'b0; cnt_r <= '0;
      dev_r <= '0; mem_r <= '0; size_r <= '0; next_r <= '0;
      base_r <= '0; hold_r <= '0;
      done_evt <= 1'b0; err_evt <= 1'b0;
    end else begin
      done_evt <= 1'b0;
      err_evt  <= 1'b0;
      if (ph == PH_IDLE && reg_we)
        case (reg_idx)
          2'd0:    dev_r  <= reg_wdata;
          2'd1:    mem_r  <= reg_wdata;
          2'd2:    size_r <= reg_wdata;
          default: next_r <= reg_wdata;
        endcase
      if (mode == 2'd0) begin
        ph <= PH_IDLE;
      end else begin
        case (ph)
          PH_IDLE:
            if (start && mode == 2'd1) begin
              ph <= PH_FETCH; base_r <= {next_r[31:2], 2'b00}; widx <= '0; chain_r <= 1'b1;
            end else if (start && mode == 2'd2) begin
              chain_r <= 1'b0;
            end
          PH_FETCH:
            if (bus_gnt) begin
              case (widx)
                2'd0:    dev_r  <= bus_rdata;
                2'd1:    mem_r  <= bus_rdata;
                2'd2:    size_r <= bus_rdata;
                default: next_r <= bus_rdata;
              endcase
              widx <= widx + 2'd1;
            end
          PH_RD:
            if (bus_gnt) begin hold_r <= bus_rdata; ph <= PH_WR; end
          default:
            if (bus_gnt) begin
              mem_r <= mem_r + wbytes; cnt_r <= cnt_r - CNT_W'(1); ph <= PH_RD;
            end
        endcase
        if (launch) begin
          if (bad) begin
            err_evt <= 1'b1; done_evt <= 1'b1; ph <= PH_IDLE;
          end else begin
            cnt_r <= count; ph <= PH_RD;
          end
        end
        if (finish) begin
          done_evt <= nxt[0];
          if (follow) begin
            ph <= PH_FETCH; base_r <= {nxt[31:2], 2'b00}; widx <= '0;
          end else begin
            ph <= PH_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_gnt,
  input logic [31:0] bus_addr,
  input logic [1:0]  state_o,
  input logic        done_evt,
  input logic        err_evt
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && mode != 2'd0 |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  // R10
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_gnt && mode != 2'd0 |=> !bus_we);

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 |=> state_o == 2'd0 && !bus_req && !done_evt);

  // R4
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> done_evt && state_o == 2'd0 && !bus_req);
endmodule

bind dma_chan_engine dma_chan_engine_chk chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .bus_req(bus_req), .bus_we(bus_we),
  .bus_gnt(bus_gnt), .bus_addr(bus_addr), .state_o(state_o),
  .done_evt(done_evt), .err_evt(err_evt)
);

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dir = 1'b0;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_rdata = 32'd0;
  logic [1:0]  state_o;
  logic        done_evt, err_evt;

  dma_chan_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .start(start), .mode(mode), .dir(dir), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_rdata(bus_rdata), .state_o(state_o), .done_evt(done_evt), .err_evt(err_evt)
  );

  int checks = 0, fails = 0;
  logic [31:0] desc_mem [0:15];
  logic [31:0] la [0:63], ld [0:63], ea [0:63], ed [0:63];
  logic        lw [0:63], ew [0:63];
  int nlog = 0, nexp = 0, ndone = 0, nerr = 0, state_bad = 0;
  int stall_cfg = 0, wait_left = 0;

  function automatic logic [31:0] rd_val(logic [31:0] a);
    if (a >= 32'h1000 && a < 32'h1040) return desc_mem[(a - 32'h1000) >> 2];
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic int wb(int wc);
    return (wc == 3) ? 1 : (wc == 2) ? 2 : 4;
  endfunction

  always @(negedge clk) begin
    if (done_evt) ndone++;
    if (err_evt) nerr++;
    bus_gnt = 1'b0;
    if (bus_req) begin
      if (wait_left > 0) wait_left--;
      else begin
        bus_gnt = 1'b1;
        bus_rdata = rd_val(bus_addr);
        if (nlog < 64) begin la[nlog] = bus_addr; lw[nlog] = bus_we; ld[nlog] = bus_wdata; end
        nlog++;
        wait_left = stall_cfg;
      end
    end
    #1;
    if (bus_req) begin
      if (state_o != (!bus_gnt ? 2'd2 : (bus_addr >= 32'h1000 && bus_addr < 32'h1040) ? 2'd1 : 2'd3))
        state_bad++;
    end else if (state_o != 2'd0) state_bad++;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [31:0] a, logic w, logic [31:0] d);
    if (nexp < 64) begin ea[nexp] = a; ew[nexp] = w; ed[nexp] = d; end
    nexp++;
  endtask

  task automatic exp_fetch(logic [31:0] base);
    for (int k = 0; k < 4; k++) push(base + 32'(4 * k), 1'b0, 32'd0);
  endtask

  task automatic exp_elems(logic [31:0] dv, logic [31:0] mb, int w, int n, bit dr);
    for (int i = 0; i < n; i++) begin
      logic [31:0] ma, src, dst;
      ma = mb + 32'(i * w);
      src = dr ? ma : dv;
      dst = dr ? dv : ma;
      push(src, 1'b0, 32'd0);
      push(dst, 1'b1, rd_val(src));
    end
  endtask

  task automatic cmp_log(string req);
    chk(nlog == nexp, req, "transfer count", 32'(nlog), 32'(nexp));
    for (int i = 0; i < 64 && i < nlog && i < nexp; i++) begin
      bit ok;
      ok = la[i] == ea[i] && lw[i] == ew[i] && (!ew[i] || ld[i] == ed[i]);
      chk(ok, req, $sformatf("transfer %0d addr/we/data", i), la[i], ea[i]);
    end
  endtask

  task automatic wr_reg(logic [1:0] i, logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_idx = i; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] i, output logic [31:0] v);
    @(negedge clk); reg_idx = i; #1 v = reg_rdata;
  endtask

  task automatic clear(int stl, bit dr);
    nlog = 0; nexp = 0; ndone = 0; nerr = 0; state_bad = 0;
    stall_cfg = stl; wait_left = stl; dir = dr;
  endtask

  task automatic go(logic [1:0] m);
    @(negedge clk); mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (bus_req) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_single(int wc, int cnt, bit dr, int fl, int stl, logic [31:0] mb);
    logic [31:0] v;
    bit badc;
    int w;
    w = wb(wc);
    badc = (wc == 1) || (cnt > ((wc == 0) ? 'h7FF : 'h3FF));
    wr_reg(2'd0, 32'h8000); wr_reg(2'd1, mb);
    wr_reg(2'd2, 32'((wc << 12) | cnt)); wr_reg(2'd3, 32'(fl));
    clear(stl, dr);
    if (!badc) exp_elems(32'h8000, mb, w, cnt, dr);
    go(2'd2);
    cmp_log(badc ? "R4" : (cnt == 0 ? "R9" : "R3/R10"));
    chk(ndone == (badc ? 1 : (fl & 1)), "R5", "done pulses", 32'(ndone), 32'(badc ? 1 : (fl & 1)));
    chk(nerr == int'(badc), "R4", "error pulses", 32'(nerr), 32'(badc));
    rd_reg(2'd1, v);
    chk(v == (badc ? mb : mb + 32'(cnt * w)), "R3", "final memory address", v, badc ? mb : mb + 32'(cnt * w));
    chk(state_bad == 0, "R7", "state code mismatches", 32'(state_bad), 32'd0);
  endtask

  initial begin
    int cnts [3] = '{0, 1, 5};
    int wcs [3] = '{3, 2, 0};
    int stls [3] = '{0, 1, 3};
    logic [31:0] v;
    for (int k = 0; k < 16; k++) desc_mem[k] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(state_o == 2'd0 && !bus_req && !done_evt && !err_evt, "R1", "reset outputs",
        {26'd0, state_o, bus_req, done_evt, err_evt, 1'b0}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd_reg(2'(i), v);
      chk(v == 32'd0, "R1", $sformatf("reset register %0d", i), v, 32'd0);
    end
    for (int i = 0; i < 4; i++) wr_reg(2'(i), 32'hC0DE_0000 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      rd_reg(2'(i), v);
      chk(v == 32'hC0DE_0000 + 32'(i), "R2", $sformatf("register %0d readback", i), v, 32'hC0DE_0000 + 32'(i));
    end

    // R3 R5 R7 R9 R10: single-mode sweep
    for (int a = 0; a < 3; a++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 3; c++)
          for (int s = 0; s < 3; s++)
            run_single(wcs[a], cnts[c], d[0], (cnts[c] + d) & 3, stls[s], 32'h2000 + 32'(a * 64));

    // R4: count limits per width and the illegal width code
    run_single(3, 'h3FF, 1'b1, 1, 0, 32'h2000);
    run_single(3, 'h400, 1'b1, 1, 0, 32'h2000);
    run_single(2, 'h3FF, 1'b0, 0, 0, 32'h2000);
    run_single(2, 'h400, 1'b0, 0, 0, 32'h2000);
    run_single(0, 'h7FF, 1'b1, 1, 0, 32'h2000);
    run_single(0, 'h800, 1'b1, 1, 0, 32'h2000);
    run_single(1, 1, 1'b1, 0, 0, 32'h2000);

    // R6 R9: chain with follow+irq, empty descriptor, last+irq
    for (int s = 0; s < 3; s += 2) begin
      desc_mem[0] = 32'h8000; desc_mem[1] = 32'h3000; desc_mem[2] = (2 << 12) | 3;  desc_mem[3] = 32'h1013;
      desc_mem[4] = 32'h8004; desc_mem[5] = 32'h3100; desc_mem[6] = (3 << 12);      desc_mem[7] = 32'h1023;
      desc_mem[8] = 32'h8008; desc_mem[9] = 32'h3200; desc_mem[10] = 32'd2;         desc_mem[11] = 32'h1;
      wr_reg(2'd1, 32'hFFFF_0000); wr_reg(2'd3, 32'h1002);
      clear(s, 1'b1);
      exp_fetch(32'h1000); exp_elems(32'h8000, 32'h3000, 2, 3, 1'b1);
      exp_fetch(32'h1010); exp_fetch(32'h1020); exp_elems(32'h8008, 32'h3200, 4, 2, 1'b1);
      go(2'd1);
      cmp_log("R6");
      chk(ndone == 3, "R6", "chain done pulses", 32'(ndone), 32'd3);
      chk(nerr == 0, "R6", "chain error pulses", 32'(nerr), 32'd0);
      rd_reg(2'd1, v);
      chk(v == 32'h3208, "R6", "chain memory address", v, 32'h3208);
      rd_reg(2'd3, v);
      chk(v == 32'h1, "R6", "chain next word loaded", v, 32'h1);
      chk(state_bad == 0, "R7", "chain state code mismatches", 32'(state_bad), 32'd0);
    end

    // R4 R6: malformed second descriptor
    desc_mem[3] = 32'h1012;
    desc_mem[6] = (1 << 12) | 2; desc_mem[7] = 32'h0;
    wr_reg(2'd3, 32'h1000);
    clear(1, 1'b1);
    exp_fetch(32'h1000); exp_elems(32'h8000, 32'h3000, 2, 3, 1'b1); exp_fetch(32'h1010);
    go(2'd1);
    cmp_log("R4");
    chk(ndone == 1 && nerr == 1, "R4", "chain error events", 32'(ndone * 16 + nerr), 32'h11);

    // R8: abort during a long copy
    wr_reg(2'd0, 32'h8000); wr_reg(2'd1, 32'h2000); wr_reg(2'd2, 32'd100); wr_reg(2'd3, 32'h1);
    clear(0, 1'b0);
    @(negedge clk); mode = 2'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (15) @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    #2;
    chk(state_o == 2'd0 && !bus_req, "R8", "idle one cycle after abort", {30'd0, state_o}, 32'd0);
    repeat (5) @(negedge clk);
    chk(ndone == 0 && nerr == 0, "R8", "no events after abort", 32'(ndone + nerr), 32'd0);

    // R2: register writes ignored while busy
    wr_reg(2'd0, 32'h8000); wr_reg(2'd1, 32'h2400); wr_reg(2'd2, 32'd20); wr_reg(2'd3, 32'h0);
    clear(2, 1'b0);
    exp_elems(32'h8000, 32'h2400, 4, 20, 1'b0);
    @(negedge clk); mode = 2'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    reg_we = 1'b1; reg_idx = 2'd1; reg_wdata = 32'hDEAD_0000;
    @(negedge clk); reg_we = 1'b0;
    while (bus_req) @(negedge clk);
    repeat (3) @(negedge clk);
    cmp_log("R2");
    rd_reg(2'd1, v);
    chk(v == 32'h2450, "R2", "busy write ignored", v, 32'h2450);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule